// File: doc/BRIEF.md
# Span Run-Length Pixel Decoder

This block turns a compressed byte stream into a stream of 8-bit pixels for a display layer or a blitter. The stream is a sequence of spans. Each span opens with a header byte. Its most significant bit selects the span kind, and its remaining bits hold a count. A solid span is followed by a single colour byte, and the decoder repeats that colour for the whole span. A copy span is followed by one byte per pixel, and the decoder forwards those bytes in order. A pixel value of zero is flagged as transparent, so a later stage can skip it instead of drawing it.

Bytes arrive on a valid/ready input. Pixels leave through a one-entry output register with valid/ready backpressure, at no more than one pixel per clock. A solid span is expanded without taking any input. A copy span takes one input byte for each pixel it puts out. When word alignment is enabled, a copy span with an odd pixel count is followed by one filler byte, which the decoder reads and drops. A start-of-image pulse puts the parser back at a span boundary and discards any pixel still waiting at the output, so a new frame can begin cleanly after an aborted one.

Top module: `span_rle_decoder`

## Requirements
- R1: After reset, `pix_valid` is 0 and `in_ready` is 1, because the parser is waiting for a header byte.
- R2: A header byte with bit 7 = 0 starts a solid span. The next byte is the colour, and the decoder outputs that colour (n+1) times, where n is header bits 6:0.
- R3: A header byte with bit 7 = 1 starts a copy span. The next (n+1) input bytes come out as pixels, unchanged and in arrival order, where n is header bits 6:0.
- R4: Whenever `pix_valid` is 1, `pix_transp` is 1 exactly when `pix_data` is 8'h00.
- R5: The count field covers span lengths from 1 (header bits 6:0 = 0) to 128 (header bits 6:0 = 127), for both span kinds.
- R6: While `pix_valid` is 1 and `pix_ready` is 0, the output holds. `pix_valid` stays 1, and `pix_data` and `pix_transp` keep their values on the next cycle.
- R7: While a solid span is being expanded, `in_ready` is 0 and no input byte is consumed.
- R8: With `WORD_ALIGN` = 1, a copy span with an odd pixel count is followed by one filler byte. That byte is consumed and never output. A copy span with an even pixel count has no filler byte.
- R9: In a cycle where `sof` is 1, `in_ready` is 0. On the next cycle `pix_valid` is 0 and the parser expects a header byte, whatever span was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-image pulse; restarts the parser |
| in_data | input | 8 | Compressed stream byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| pix_data | output | 8 | Decoded pixel value |
| pix_valid | output | 1 | `pix_data` holds a pixel |
| pix_transp | output | 1 | Pixel value is zero (transparent) |
| pix_ready | input | 1 | Downstream accepts the pixel this cycle |

## Verification
Two events can fall in the same cycle: a start-of-image pulse, and a pixel that is stalled at the output in the middle of a solid span while a new header byte is already offered on the input. The bench holds `pix_ready` low partway through a long solid span, checks that the pixel is frozen, and then raises `sof` together with `in_valid`. It then checks that the byte was refused during the pulse and that the pending pixel is gone on the next cycle. A fresh span follows, and the scoreboard accepts it only if none of the aborted span's colour leaks out after it.

// File: rtl/span_rle_pkg.sv
package span_rle_pkg;

    typedef enum logic [2:0] {
        S_HDR  = 3'd0,
        S_FCOL = 3'd1,
        S_FILL = 3'd2,
        S_LIT  = 3'd3,
        S_PAD  = 3'd4
    } span_st_e;

endpackage

// File: rtl/span_hdr_split.sv
module span_hdr_split #(
    parameter int PIX_W      = 8,
    parameter bit WORD_ALIGN = 1'b1,
    localparam int LEN_W     = PIX_W - 1
) (
    input  logic [PIX_W-1:0] hdr_byte,
    output logic             hdr_lit,
    output logic [LEN_W-1:0] hdr_len,
    output logic             hdr_pad
);

    always_comb begin
        hdr_lit = hdr_byte[PIX_W-1];
        hdr_len = hdr_byte[LEN_W-1:0];
        // the pixel count is len+1, so it is odd when len is even
        hdr_pad = WORD_ALIGN && hdr_lit && !hdr_byte[0];
    end

endmodule

// File: rtl/span_rle_fsm.sv
module span_rle_fsm
    import span_rle_pkg::*;
#(
    parameter int PIX_W  = 8,
    localparam int LEN_W = PIX_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             hdr_lit,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             hdr_pad,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_valid,
    output logic             pix_transp,
    input  logic             pix_ready
);

    typedef struct packed {
        span_st_e         st;
        logic [LEN_W-1:0] cnt;
        logic [PIX_W-1:0] col;
        logic             pad;
        logic [PIX_W-1:0] pix;
        logic             pix_vld;
        logic             pix_tr;
    } fsm_t;

    fsm_t q, d;
    logic can_emit;

    always_comb begin
        d        = q;
        in_ready = 1'b0;
        can_emit = !q.pix_vld || pix_ready;
        if (q.pix_vld && pix_ready) begin
            d.pix_vld = 1'b0;
        end
        unique case (q.st)
            S_HDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.cnt = hdr_len;
                    d.pad = hdr_pad;
                    d.st  = hdr_lit ? S_LIT : S_FCOL;
                end
            end
            S_FCOL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.col = in_data;
                    d.st  = S_FILL;
                end
            end
            S_FILL: begin
                if (can_emit) begin
                    d.pix     = q.col;
                    d.pix_tr  = (q.col == '0);
                    d.pix_vld = 1'b1;
                    if (q.cnt == '0) begin
                        d.st = S_HDR;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            S_LIT: begin
                in_ready = can_emit;
                if (in_valid && can_emit) begin
                    d.pix     = in_data;
                    d.pix_tr  = (in_data == '0);
                    d.pix_vld = 1'b1;
                    if (q.cnt == '0) begin
                        d.st = q.pad ? S_PAD : S_HDR;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            S_PAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.st = S_HDR;
                end
            end
            default: d.st = S_HDR;
        endcase
        if (sof) begin
            d         = q;
            d.st      = S_HDR;
            d.pix_vld = 1'b0;
            in_ready  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_HDR, default: '0};
        end else begin
            q <= d;
        end
    end

    assign pix_data   = q.pix;
    assign pix_valid  = q.pix_vld;
    assign pix_transp = q.pix_tr;

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready && !sof) |=> (pix_valid && $stable(pix_data) && $stable(pix_transp))) // R6
        else $error("stalled pixel changed");

    AST_TRANSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_transp == (pix_data == '0))) // R4
        else $error("transparency flag mismatch");

    AST_FILL_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FILL) |-> !in_ready) // R7
        else $error("input taken during solid span");

    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!pix_valid && q.st == S_HDR)) // R9
        else $error("start-of-image did not restart parser");

    AST_LIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_LIT && in_valid && in_ready && !sof) |=> (pix_valid && pix_data == $past(in_data))) // R3
        else $error("copy byte not forwarded");

endmodule

// File: rtl/span_rle_decoder.sv
module span_rle_decoder #(
    parameter int PIX_W      = 8,
    parameter bit WORD_ALIGN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_valid,
    output logic             pix_transp,
    input  logic             pix_ready
);

    localparam int LEN_W = PIX_W - 1;

    logic             hdr_lit;
    logic [LEN_W-1:0] hdr_len;
    logic             hdr_pad;

    span_hdr_split #(
        .PIX_W     (PIX_W),
        .WORD_ALIGN(WORD_ALIGN)
    ) u_split (
        .hdr_byte(in_data),
        .hdr_lit (hdr_lit),
        .hdr_len (hdr_len),
        .hdr_pad (hdr_pad)
    );

    span_rle_fsm #(
        .PIX_W(PIX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .hdr_lit   (hdr_lit),
        .hdr_len   (hdr_len),
        .hdr_pad   (hdr_pad),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_transp(pix_transp),
        .pix_ready (pix_ready)
    );

endmodule

// File: tb/span_rle_decoder_bench.sv
module span_rle_decoder_bench;

    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] pix_data;
    logic       pix_valid;
    logic       pix_transp;
    logic       pix_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    span_rle_decoder u_span_rle_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_transp(pix_transp),
        .pix_ready (pix_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit took;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        forever begin
            #(CLK_PER/2 - 1);
            took = in_ready;
            @(posedge clk);
            if (took) break;
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    // R2: solid span of n pixels
    task automatic send_fill(input int n, input logic [7:0] c);
        send_byte(8'(n - 1));
        send_byte(c);
        repeat (n) push(c, "R2");
    endtask

    // R3: copy span of n pixels, R8 filler after odd counts
    task automatic send_lit(input int n, input int seed);
        send_byte(8'h80 | 8'(n - 1));
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = (((seed + i * 29) % 5) == 0) ? 8'h00 : 8'(seed + i * 29);
            send_byte(v);
            push(v, "R3");
        end
        if ((n % 2) == 1) send_byte(8'hEE);
    endtask

    task automatic drain();
        int w = 0;
        while (exp_q.size() > 0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            pix_ready = stall ? 1'b0 : (($urandom % 4) != 0);
            #(CLK_PER/2 - 1);
            if (rst_n && pix_valid && pix_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", pix_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(pix_data == e, t, pix_data, e);
                    chk(pix_transp == (e == 8'h00), "R4", pix_transp, (e == 8'h00));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(pix_valid == 1'b0, "R1", pix_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);

        // stalled solid span: output frozen, no input taken (R6, R7)
        stall = 1'b1;
        send_fill(4, 8'h5A);
        repeat (3) @(negedge clk);
        #1;
        chk(pix_valid == 1'b1, "R6", pix_valid, 1);
        chk(pix_data == 8'h5A, "R6", pix_data, 8'h5A);
        chk(in_ready == 1'b0, "R7", in_ready, 0);
        repeat (2) @(negedge clk);
        #1;
        chk(pix_data == 8'h5A && pix_valid, "R6", pix_data, 8'h5A);
        stall = 1'b0;
        drain();

        // length extremes and mixed spans (R5, R4, R8)
        send_fill(1, 8'h11);
        send_fill(128, 8'h00);
        send_lit(1, 7);
        send_lit(2, 40);
        send_lit(7, 3);
        send_lit(128, 91);
        send_fill(3, 8'h22);
        send_lit(5, 10);
        drain();

        // start-of-image while a pixel is stalled mid solid span (R9)
        stall = 1'b1;
        send_byte(8'h09);
        send_byte(8'h33);
        repeat (2) @(negedge clk);
        #1;
        chk(pix_valid == 1'b1 && pix_data == 8'h33, "R6", pix_data, 8'h33);
        @(negedge clk);
        sof = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h81;
        #(CLK_PER/2 - 1);
        chk(in_ready == 1'b0, "R9", in_ready, 0);
        @(posedge clk);
        #1;
        sof = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(pix_valid == 1'b0, "R9", pix_valid, 0);
        chk(in_ready == 1'b1, "R9", in_ready, 1);
        stall = 1'b0;
        send_fill(2, 8'h44);
        send_lit(3, 55);
        drain();

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule